// File: doc/BRIEF.md
# Bus-Attached Iterative Integer Divider

This block is a 32-bit quotient-and-remainder unit on a simple register bus. Writes take effect on the clock edge and reads are combinational. Software stores a dividend and a divisor through one of two address pairs. Which pair is used decides whether the operands are treated as two's-complement or as unsigned numbers. The unit then runs a restoring divide that retires four quotient bits per clock. After exactly eight clocks it holds the quotient and remainder in two readable registers.

Every operand and result register can be read and written. An interrupt handler can therefore save the whole context and put it back later without running a new division. A status word shows whether a result is ready. It also shows whether the result is still unconsumed; reading the quotient consumes it, so software reads the remainder first and the quotient last.

Top module: `mmio_divider`

## Requirements
- R1: Word addresses 0 and 1 take the dividend and divisor for an unsigned divide. Addresses 2 and 3 take them for a signed divide. The signedness comes from the address of the most recent operand write.
- R2: After the last operand write, status ready (bit 0 of address 6) reads 0 for seven clocks and 1 on the eighth clock. From then on, the quotient (address 4) and remainder (address 5) hold the result.
- R3: Addresses 0 and 1 always read back the last dividend and divisor written, whichever pair was used to write them.
- R4: An unsigned divide yields the floor quotient and a remainder smaller than the divisor.
- R5: A signed divide truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R6: Dividing by zero raises no error. An unsigned divide gives a quotient of all ones and a remainder equal to the dividend. A signed divide gives a quotient of +1 for a negative dividend and -1 otherwise, and a remainder equal to the dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0.
- R8: Writing the quotient or remainder address stores the bus value there, sets ready, and abandons any divide in flight. The abandoned divide then changes neither result register.
- R9: Completion sets dirty (bit 1 of address 6). A read of address 4 clears dirty; a read of address 5 does not.
- R10: The status word is {30'b0, dirty, ready}. Any operand write clears ready.
- R11: If completion falls in the same clock as a quotient read, dirty ends up set and the read returns the previous quotient. If it falls in the same clock as an operand write, the divide restarts and ready stays 0.
- R12: After reset, every register and the status word read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, only meaningful for the quotient-consume side effect |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The final divide step can land in the same clock as a quotient read, or in the same clock as a new operand write. The bench provokes both: it counts seven clocks after an operand write and then issues the read or the write on the eighth edge. For the read case, it checks that the old quotient came back and that the status word shows both ready and dirty afterwards. For the write case, it checks that ready stays low and that the later result belongs to the new operands.

// File: rtl/divider_pkg.sv
`timescale 1ns/1ps
package divider_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_UDEND = 3'd0,
        A_UDSR  = 3'd1,
        A_SDEND = 3'd2,
        A_SDSR  = 3'd3,
        A_QUOT  = 3'd4,
        A_REM   = 3'd5,
        A_STAT  = 3'd6
    } div_addr_e;
endpackage

// File: rtl/div_cond_neg.sv
`timescale 1ns/1ps
// Two's-complement negate when requested; used for operand magnitude and result sign fix.
module div_cond_neg #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             negate_i,
    output logic [WIDTH-1:0] value_o
);
    assign value_o = negate_i ? (~value_i + WIDTH'(1)) : value_i;
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
// One clock worth of restoring division: BITS radix-2 stages chained.
module div_step #(
    parameter int WIDTH = 32,
    parameter int BITS  = 4
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [BITS:0][WIDTH-1:0] rem_s;
    logic [BITS:0][WIDTH-1:0] quo_s;

    assign rem_s[0] = rem_i;
    assign quo_s[0] = quo_i;

    for (genvar g = 0; g < BITS; g++) begin : g_stage
        logic [WIDTH:0]   ext;
        logic             ge;
        logic [WIDTH-1:0] diff;
        assign ext  = {rem_s[g], quo_s[g][WIDTH-1]};
        assign ge   = ext >= {1'b0, dvs_i};
        assign diff = ext[WIDTH-1:0] - dvs_i;
        assign rem_s[g+1] = ge ? diff : ext[WIDTH-1:0];
        assign quo_s[g+1] = {quo_s[g][WIDTH-2:0], ge};
    end

    assign rem_o = rem_s[BITS];
    assign quo_o = quo_s[BITS];
endmodule

// File: rtl/mmio_divider.sv
`timescale 1ns/1ps
module mmio_divider
    import divider_pkg::*;
#(
    parameter int WIDTH          = 32,
    parameter int BITS_PER_CYCLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata
);
    localparam int STEPS = WIDTH / BITS_PER_CYCLE;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic [WIDTH-1:0] dividend;
        logic [WIDTH-1:0] divisor;
        logic [WIDTH-1:0] quotient;
        logic [WIDTH-1:0] remainder;
        logic [WIDTH-1:0] w_rem;
        logic [WIDTH-1:0] w_quo;
        logic [WIDTH-1:0] w_dvs;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             ready;
        logic             dirty;
        logic             is_signed;
        logic             neg_q;
        logic             neg_r;
    } div_state_t;

    div_state_t st_q, st_d;

    // Bus decode
    logic op_wr, res_wr, q_rd, done;
    assign op_wr  = bus_wr && (bus_addr <= A_SDSR);
    assign res_wr = bus_wr && (bus_addr == A_QUOT || bus_addr == A_REM);
    assign q_rd   = bus_rd && (bus_addr == A_QUOT);
    assign done   = st_q.busy && (st_q.cnt == CNT_W'(STEPS - 1)) && !op_wr && !res_wr;

    // Operands as they stand after this cycle's write
    logic [WIDTH-1:0] nxt_dend, nxt_dsr;
    logic             nxt_sgn;
    assign nxt_dend = (op_wr && !bus_addr[0]) ? bus_wdata : st_q.dividend;
    assign nxt_dsr  = (op_wr &&  bus_addr[0]) ? bus_wdata : st_q.divisor;
    assign nxt_sgn  = op_wr ? bus_addr[1] : st_q.is_signed;

    logic [WIDTH-1:0] mag_a, mag_b, step_rem, step_quo, fin_q, fin_r;

    div_cond_neg #(.WIDTH(WIDTH)) u_abs_a (
        .value_i (nxt_dend),
        .negate_i(nxt_sgn && nxt_dend[WIDTH-1]),
        .value_o (mag_a)
    );
    div_cond_neg #(.WIDTH(WIDTH)) u_abs_b (
        .value_i (nxt_dsr),
        .negate_i(nxt_sgn && nxt_dsr[WIDTH-1]),
        .value_o (mag_b)
    );
    div_step #(.WIDTH(WIDTH), .BITS(BITS_PER_CYCLE)) u_step (
        .rem_i(st_q.w_rem),
        .quo_i(st_q.w_quo),
        .dvs_i(st_q.w_dvs),
        .rem_o(step_rem),
        .quo_o(step_quo)
    );
    div_cond_neg #(.WIDTH(WIDTH)) u_fix_q (
        .value_i (step_quo),
        .negate_i(st_q.neg_q),
        .value_o (fin_q)
    );
    div_cond_neg #(.WIDTH(WIDTH)) u_fix_r (
        .value_i (step_rem),
        .negate_i(st_q.neg_r),
        .value_o (fin_r)
    );

    always_comb begin
        st_d           = st_q;
        st_d.dividend  = nxt_dend;
        st_d.divisor   = nxt_dsr;
        st_d.is_signed = nxt_sgn;

        if (st_q.busy) begin
            st_d.w_rem = step_rem;
            st_d.w_quo = step_quo;
            st_d.cnt   = st_q.cnt + CNT_W'(1);
        end

        // Completion outranks a simultaneous consume
        if (done) begin
            st_d.busy      = 1'b0;
            st_d.quotient  = fin_q;
            st_d.remainder = fin_r;
            st_d.ready     = 1'b1;
            st_d.dirty     = 1'b1;
        end else if (q_rd) begin
            st_d.dirty = 1'b0;
        end

        if (res_wr) begin
            st_d.busy  = 1'b0;
            st_d.ready = 1'b1;
            if (bus_addr == A_QUOT) st_d.quotient  = bus_wdata;
            else                    st_d.remainder = bus_wdata;
        end

        if (op_wr) begin
            st_d.busy  = 1'b1;
            st_d.ready = 1'b0;
            st_d.cnt   = '0;
            st_d.w_rem = '0;
            st_d.w_quo = mag_a;
            st_d.w_dvs = mag_b;
            st_d.neg_q = nxt_sgn && (nxt_dend[WIDTH-1] ^ nxt_dsr[WIDTH-1]);
            st_d.neg_r = nxt_sgn && nxt_dend[WIDTH-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_UDEND, A_SDEND: bus_rdata = st_q.dividend;
            A_UDSR,  A_SDSR:  bus_rdata = st_q.divisor;
            A_QUOT:           bus_rdata = st_q.quotient;
            A_REM:            bus_rdata = st_q.remainder;
            A_STAT:           bus_rdata = {{(WIDTH-2){1'b0}}, st_q.dirty, st_q.ready};
            default:          bus_rdata = '0;
        endcase
    end

    // Observation points for the bound checker
    logic ready_s, dirty_s, busy_s, done_s;
    assign ready_s = st_q.ready;
    assign dirty_s = st_q.dirty;
    assign busy_s  = st_q.busy;
    assign done_s  = done;
endmodule

// File: rtl/div_checker.sv
`timescale 1ns/1ps
module div_checker #(
    parameter int WIDTH = 32,
    parameter int STEPS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       ready_s,
    input logic       dirty_s,
    input logic       busy_s,
    input logic       done_s
);
    localparam int SW = $clog2(STEPS + 2);

    logic          op_w, res_w, q_r;
    logic [SW-1:0] since_wr;
    logic          prev_ready, prev_res;

    assign op_w  = bus_wr && (bus_addr <= 3'd3);
    assign res_w = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5);
    assign q_r   = bus_rd && (bus_addr == 3'd4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_wr   <= SW'(STEPS + 1);
            prev_ready <= 1'b0;
            prev_res   <= 1'b0;
        end else begin
            if (op_w)                           since_wr <= '0;
            else if (since_wr != SW'(STEPS + 1)) since_wr <= since_wr + SW'(1);
            prev_ready <= ready_s;
            prev_res   <= res_w;
        end
    end

    // R2: ready rises only STEPS clocks after the last operand write
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_s && !prev_ready && !prev_res) |-> (since_wr == SW'(STEPS)));

    p_opwrite_clears_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_w |=> (!ready_s && busy_s));

    p_reswrite_sets_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_w && !op_w) |=> (ready_s && !busy_s));

    p_qread_clears_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r && !done_s) |=> !dirty_s);

    p_done_wins_dirty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_s |=> (dirty_s && ready_s && !busy_s));
endmodule

bind mmio_divider div_checker #(.WIDTH(WIDTH), .STEPS(STEPS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .ready_s (ready_s),
    .dirty_s (dirty_s),
    .busy_s  (busy_s),
    .done_s  (done_s)
);

// File: tb/tb_mmio_divider.sv
`timescale 1ns/1ps
module tb_mmio_divider;
    import divider_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [31:0] q; logic [31:0] r; } exp_t;
    exp_t sb[$];

    mmio_divider dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input bit sgn, input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        if (b == 0) begin
            e.r = a;
            e.q = (sgn && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
        end else if (!sgn) begin
            e.q = a / b;
            e.r = a % b;
        end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            e.q = a;
            e.r = 0;
        end else begin
            e.q = $signed(a) / $signed(b);
            e.r = $signed(a) % $signed(b);
        end
        return e;
    endfunction

    // All bus tasks start and end just after a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver: writes operands and pushes the expected result
    task automatic drive_div(input bit sgn, input logic [31:0] a, input logic [31:0] b);
        sb.push_back(model(sgn, a, b));
        bus_write(sgn ? A_SDEND : A_UDEND, a);
        bus_write(sgn ? A_SDSR : A_UDSR, b);
    endtask

    // Monitor: measures latency, reads remainder then quotient, compares with the queue
    task automatic monitor_result(input string req);
        logic [31:0] v, rq, rr;
        int lat = 0;
        exp_t e;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            peek(A_STAT, v);
            if (v[0] && lat == 0) lat = i;
        end
        check("R2 latency", lat, 8);
        bus_read(A_REM, rr);
        bus_read(A_QUOT, rq);
        e = sb.pop_front();
        check({req, " quotient"}, rq, e.q);
        check({req, " remainder"}, rr, e.r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, oldq, oldr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        peek(A_STAT, v);  check("R12 status", v, 0);
        peek(A_QUOT, v);  check("R12 quotient", v, 0);
        peek(A_UDEND, v); check("R12 dividend", v, 0);

        // R4 unsigned
        drive_div(0, 100, 7);                    monitor_result("R4 100/7");
        drive_div(0, 32'hFFFF_FFFF, 32'h10);     monitor_result("R4 max/16");
        drive_div(0, 5, 9);                      monitor_result("R4 small/large");

        // R5 signed, R1 same bits through unsigned pair differ
        drive_div(1, -32'sd7, 32'd2);            monitor_result("R5 -7/2");
        drive_div(1, 32'd7, -32'sd2);            monitor_result("R5 7/-2");
        drive_div(1, -32'sd7, -32'sd2);          monitor_result("R5 -7/-2");
        drive_div(0, 32'hFFFF_FFF9, 32'd2);      monitor_result("R1 unsigned pair");
        drive_div(1, 32'hFFFF_FFF9, 32'd2);      monitor_result("R1 signed pair");

        // R3 readback through unsigned addresses after signed writes
        peek(A_UDEND, v); check("R3 dividend readback", v, 32'hFFFF_FFF9);
        peek(A_UDSR, v);  check("R3 divisor readback", v, 32'd2);

        // R6 divide by zero
        drive_div(0, 32'h1234, 0);               monitor_result("R6 unsigned /0");
        drive_div(1, 32'h1234, 0);               monitor_result("R6 signed pos /0");
        drive_div(1, -32'sd50, 0);               monitor_result("R6 signed neg /0");

        // R7 overflow case
        drive_div(1, 32'h8000_0000, 32'hFFFF_FFFF); monitor_result("R7 min/-1");

        // R9/R10 dirty and status layout
        drive_div(0, 81, 9);
        repeat (10) @(negedge clk);
        peek(A_STAT, v);  check("R10 status after done", v, 3);
        bus_read(A_REM, v);
        peek(A_STAT, v);  check("R9 remainder read keeps dirty", v, 3);
        bus_read(A_QUOT, v); check("R9 quotient value", v, 9);
        peek(A_STAT, v);  check("R9 quotient read clears dirty", v, 1);
        void'(sb.pop_front());

        // R8 direct result write aborts divide in flight
        drive_div(0, 1000, 3);
        void'(sb.pop_front());
        peek(A_REM, oldr);
        repeat (3) @(negedge clk);
        bus_write(A_QUOT, 32'h1234);
        peek(A_STAT, v);  check("R8 ready after result write", v, 1);
        repeat (10) @(negedge clk);
        peek(A_QUOT, v);  check("R8 quotient kept", v, 32'h1234);
        peek(A_REM, v);   check("R8 remainder untouched", v, oldr);
        bus_write(A_REM, 32'h55);
        peek(A_REM, v);   check("R8 remainder write", v, 32'h55);

        // R11 completion and quotient read in the same clock
        peek(A_QUOT, oldq);
        drive_div(0, 200, 10);
        repeat (7) @(negedge clk);
        bus_read(A_QUOT, v);
        check("R11 read returns old quotient", v, oldq);
        peek(A_STAT, v);  check("R11 dirty survives read", v, 3);
        peek(A_QUOT, v);  check("R11 new quotient", v, sb[0].q);
        void'(sb.pop_front());
        bus_read(A_QUOT, v);

        // R11 completion and operand write in the same clock
        bus_write(A_UDEND, 300);
        bus_write(A_UDSR, 7);
        repeat (7) @(negedge clk);
        sb.push_back(model(0, 91, 7));
        bus_write(A_UDEND, 91);
        peek(A_STAT, v);  check("R11 write restarts, ready low", v[0], 0);
        bus_write(A_UDSR, 7);
        monitor_result("R11 restarted result");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule